// File: doc/BRIEF.md
# SMBus Register Slave with Counted Block Reads

This block is a two-wire serial slave that fronts a 256-byte register space. It watches SCL and SDA with the system clock, drives SDA only by pulling it low, and reaches the register storage through a synchronous port: the address goes out in one cycle and the read data comes back in the next. A master first writes a one-byte command after the slave address. It then either keeps writing data, which fills successive registers, or issues a repeated START and reads.

A command outside the block range F2h..FDh is a register address, and the read that follows streams bytes upward from it. A command inside that range is a block code. The read phase then begins with a byte count, and the data bytes follow it from a start address taken from a small computed table. The slave keeps supplying bytes for as long as the master acknowledges them. The pointer stops at the top of the space and does not wrap, and bytes beyond the implemented region read as 00h.

States: IDLE (bus free), ADDR (shifting the address byte), AACK (acknowledging the address), CMD (shifting the command byte), CACK, WDAT (shifting a write byte), WACK, RDAT (sending a byte), RACK (sampling the master's acknowledge), IGN (released until the next START or STOP). Transitions: START goes to ADDR from any state and STOP goes to IDLE from any state. ADDR goes to AACK on a match and to IGN otherwise. AACK goes to RDAT on a read bit and to CMD on a write bit. CMD goes to CACK, then to WDAT. WDAT and WACK alternate. RDAT goes to RACK. RACK goes back to RDAT on ACK and to IGN on NACK.

Top module: `smb_blk_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 2Ch). For any other address it leaves SDA released until the next START or STOP, including every acknowledge slot.
- R2: In a write transaction (address with bit0 = 0, command byte, then data bytes), each data byte is acknowledged and written to the register selected by the pointer, and the pointer then moves up by one.
- R3: After a command that is not a block code, a repeated START and a read address (bit0 = 1), the bytes returned are the registers from that address upward, most significant bit first.
- R4: After a block code F2h+i with i < 4, the first read byte is the count 2+i, and the data that follows starts at register 16*i.
- R5: Block codes F6h..FDh return a count of 00h.
- R6: Registers above MAP_TOP (default BFh) read as 00h, and writes to them are dropped.
- R7: The pointer never wraps past FFh. Every byte read after FFh is 00h.
- R8: While the master keeps acknowledging, the slave keeps sending further bytes, including bytes beyond a block count.
- R9: After a NACK from the master, SDA stays released even if SCL keeps toggling, until START or STOP.
- R10: A START or STOP at any bit position aborts the current byte and returns to address matching. A byte cut short this way writes nothing.
- R11: After reset SDA is released and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_addr | output | 8 | Register address for the storage port |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_addr |

## Verification
The hardest case to reach is a pointer that has run past FFh. Only a read that starts near the top and is acknowledged several bytes beyond the end gets there. The stimulus starts at FEh and acknowledges five bytes. Register 00h holds a nonzero value, so a wrap would show up on SDA. Aborts in the middle of a byte are just as awkward to produce. The bench raises SDA while SCL is high after three or four bits, then proves through later reads that nothing was written and that the next address byte was matched afresh.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

    localparam int PTR_W = 9;
    localparam logic [7:0] BLK_FIRST = 8'hF2;
    localparam logic [7:0] BLK_LAST  = 8'hFD;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_CMD,
        ST_CACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_IGN
    } st_e;

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_p;
    logic         sda_p;
    logic         scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_p    <= scl_pipe[TOP];
            sda_p    <= sda_pipe[TOP];
        end
    end

    assign scl_s     = scl_pipe[TOP];
    assign sda_s     = sda_pipe[TOP];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_blk_map.sv
module smb_blk_map
    import smb_blk_pkg::*;
#(
    parameter logic [7:0] BLK_USED   = 8'd4,
    parameter logic [7:0] BLK_LEN    = 8'd2,
    parameter logic [7:0] BLK_STRIDE = 8'd16
) (
    input  logic [7:0] code,
    output logic       is_blk,
    output logic [7:0] count,
    output logic [7:0] start
);
    logic [7:0] idx;

    always_comb begin
        idx    = code - BLK_FIRST;
        is_blk = (code >= BLK_FIRST) && (code <= BLK_LAST);
        count  = 8'h00;
        start  = 8'h00;
        if (is_blk && (idx < BLK_USED)) begin
            count = BLK_LEN + idx;
            start = idx * BLK_STRIDE;
        end
    end

endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave
    import smb_blk_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2C,
    parameter logic [7:0] MAP_TOP     = 8'hBF,
    parameter logic [7:0] BLK_USED    = 8'd4,
    parameter logic [7:0] BLK_LEN     = 8'd2,
    parameter logic [7:0] BLK_STRIDE  = 8'd16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] mem_addr,
    output logic       mem_wr,
    output logic [7:0] mem_wdata,
    input  logic [7:0] mem_rdata
);
    localparam logic [3:0]       BYTE_BITS = 4'd8;
    localparam logic [PTR_W-1:0] MAP_LIMIT = {1'b0, MAP_TOP};

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic is_blk;
    logic [7:0] blk_count, blk_start;

    st_e              st_q, st_d;
    logic [3:0]       bitcnt_q;
    logic [7:0]       sh_q;
    logic [7:0]       tx_q;
    logic [PTR_W-1:0] ptr_q;
    logic [7:0]       cnt_q;
    logic             rw_q, cnt_ph_q, nack_q;
    logic [7:0]       tx_byte;
    logic             byte_end;
    logic [PTR_W-1:0] ptr_next;

    smb_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_blk_map #(.BLK_USED(BLK_USED), .BLK_LEN(BLK_LEN), .BLK_STRIDE(BLK_STRIDE)) u_map (
        .code(sh_q), .is_blk(is_blk), .count(blk_count), .start(blk_start)
    );

    assign byte_end = scl_fall && (bitcnt_q == BYTE_BITS);
    assign ptr_next = ptr_q[PTR_W-1] ? ptr_q : ptr_q + 1'b1;

    always_comb begin
        if (cnt_ph_q)
            tx_byte = cnt_q;
        else if (ptr_q > MAP_LIMIT)
            tx_byte = 8'h00;
        else
            tx_byte = mem_rdata;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (stop_det) begin
            st_d = ST_IDLE;
        end else if (start_det) begin
            st_d = ST_ADDR;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_ADDR: if (byte_end) st_d = (sh_q[7:1] == DEV_ADDR) ? ST_AACK : ST_IGN;
                ST_AACK: if (scl_fall) st_d = rw_q ? ST_RDAT : ST_CMD;
                ST_CMD:  if (byte_end) st_d = ST_CACK;
                ST_CACK: if (scl_fall) st_d = ST_WDAT;
                ST_WDAT: if (byte_end) st_d = ST_WACK;
                ST_WACK: if (scl_fall) st_d = ST_WDAT;
                ST_RDAT: if (byte_end) st_d = ST_RACK;
                ST_RACK: if (scl_fall) st_d = nack_q ? ST_IGN : ST_RDAT;
                ST_IGN:  st_d = ST_IGN;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            bitcnt_q <= '0;
            sh_q     <= '0;
            tx_q     <= '0;
            ptr_q    <= '0;
            cnt_q    <= '0;
            rw_q     <= 1'b0;
            cnt_ph_q <= 1'b0;
            nack_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (start_det || stop_det) begin
                bitcnt_q <= '0;
            end else begin
                unique case (st_q)
                    ST_ADDR, ST_CMD, ST_WDAT: begin
                        if (scl_rise) begin
                            sh_q     <= {sh_q[6:0], sda_s};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                        if (byte_end) begin
                            bitcnt_q <= '0;
                            if (st_q == ST_ADDR) rw_q <= sh_q[0];
                            if (st_q == ST_WDAT) ptr_q <= ptr_next;
                            if (st_q == ST_CMD) begin
                                cnt_ph_q <= is_blk;
                                cnt_q    <= blk_count;
                                ptr_q    <= is_blk ? {1'b0, blk_start} : {1'b0, sh_q};
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall && rw_q) begin
                            tx_q     <= tx_byte;
                            bitcnt_q <= '0;
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise) bitcnt_q <= bitcnt_q + 1'b1;
                        if (byte_end) bitcnt_q <= '0;
                        else if (scl_fall) tx_q <= {tx_q[6:0], 1'b0};
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_s;
                            if (cnt_ph_q) cnt_ph_q <= 1'b0;
                            else ptr_q <= ptr_next;
                        end
                        if (scl_fall && !nack_q) tx_q <= tx_byte;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr  = ptr_q[7:0];
        mem_wdata = sh_q;
        mem_wr    = (st_q == ST_WDAT) && byte_end && !start_det && !stop_det
                    && (ptr_q <= MAP_LIMIT);
        unique case (st_q)
            ST_AACK, ST_CACK, ST_WACK: sda_oe = 1'b1;
            ST_RDAT:                   sda_oe = ~tx_q[7];
            default:                   sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/smb_blk_slave_chk.sv
module smb_blk_slave_chk
    import smb_blk_pkg::*;
#(
    parameter logic [7:0] MAP_TOP = 8'hBF
) (
    input logic             clk,
    input logic             rst_n,
    input st_e              st,
    input logic [PTR_W-1:0] ptr,
    input logic             sda_oe,
    input logic             mem_wr,
    input logic [7:0]       mem_addr,
    input logic             start_det,
    input logic             stop_det
);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    assert_ign_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGN) |-> !sda_oe);

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE));

    assert_start_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (st == ST_ADDR));

    assert_wr_mapped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (!ptr[PTR_W-1] && (mem_addr <= MAP_TOP)));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr[PTR_W-1] && (st != ST_CMD)) |=> ptr[PTR_W-1]);

endmodule

bind smb_blk_slave smb_blk_slave_chk #(.MAP_TOP(MAP_TOP)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st_q), .ptr(ptr_q), .sda_oe(sda_oe),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/smb_blk_slave_tb.sv
`timescale 1ns/1ps
module smb_blk_slave_tb;
    localparam int Q = 5;
    localparam logic [6:0] DEV = 7'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, mem_wr;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;

    logic [7:0] store   [256];
    logic [7:0] ref_mem [256];
    logic [7:0] exq [$];
    int checks = 0;
    int errors = 0;
    logic exp_drv = 1'b0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    string cur_req = "R11";

    assign sda_line = sda_m & ~sda_oe;
    always #10 clk = ~clk;

    smb_blk_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_wr) store[mem_addr] <= mem_wdata;
        mem_rdata <= store[mem_addr];
    end

    // per-clock comparison of the SDA drive against the behavioural expectation
    always @(negedge clk) begin
        if (mon_en && scl && rst_n && !done) begin
            checks++;
            if (sda_oe !== exp_drv) begin
                errors++;
                $display("FAIL %s sda drive act=%b exp=%b t=%0t", cur_req, sda_oe, exp_drv, $time);
            end
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic bit_w(input logic b, input logic e);
        sda_m = b; exp_drv = e;
        w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    endtask

    task automatic start_c;
        exp_drv = 1'b0; sda_m = 1'b1; w(Q); scl = 1'b1; w(Q);
        sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
    endtask

    task automatic stop_c;
        exp_drv = 1'b0; sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic ack_exp);
        for (int i = 7; i >= 0; i--) bit_w(b[i], 1'b0);
        bit_w(1'b1, ack_exp);
        chk(1'b1, "byte sent", b, b);
    endtask

    task automatic rd_byte(input logic [7:0] e, input logic mack);
        logic [7:0] g;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; exp_drv = ~e[i];
            w(Q); scl = 1'b1; w(Q); g[i] = sda_line; w(Q); scl = 1'b0; w(Q);
        end
        bit_w(~mack, 1'b0);
        chk(g == e, "read byte", g, e);
    endtask

    task automatic rd_list;
        for (int i = 0; i < exq.size(); i++) rd_byte(exq[i], i != exq.size() - 1);
        exq.delete();
    endtask

    task automatic set_ptr_read(input logic [7:0] cmd);
        start_c;
        wr_byte({DEV, 1'b0}, 1'b1);
        wr_byte(cmd, 1'b1);
        start_c;
        wr_byte({DEV, 1'b1}, 1'b1);
    endtask

    function automatic logic [7:0] mref(input int a);
        if (a > 255 || a > 8'hBF) return 8'h00;
        return ref_mem[a];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL %s watchdog expired act=%h exp=%h", cur_req, 8'h00, 8'h01);
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            store[i]   = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
        w(5);
        cur_req = "R11";
        chk(sda_oe == 1'b0, "sda released in reset", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        w(10);
        chk(sda_oe == 1'b0 && mem_wr == 1'b0, "idle after reset R11", {6'd0, sda_oe, mem_wr}, 8'h00);
        mon_en = 1'b1;

        // R1 + R2: write three bytes from 10h
        cur_req = "R2";
        start_c;
        wr_byte({DEV, 1'b0}, 1'b1);
        wr_byte(8'h10, 1'b1);
        wr_byte(8'hA1, 1'b1);
        wr_byte(8'hA2, 1'b1);
        wr_byte(8'hA3, 1'b1);
        stop_c;
        ref_mem[8'h10] = 8'hA1; ref_mem[8'h11] = 8'hA2; ref_mem[8'h12] = 8'hA3;

        // R3: sequential read from 0Fh
        cur_req = "R3";
        set_ptr_read(8'h0F);
        for (int a = 8'h0F; a <= 8'h13; a++) exq.push_back(mref(a));
        rd_list;
        stop_c;

        // R1: foreign address, no acknowledge anywhere
        cur_req = "R1";
        start_c;
        wr_byte({7'h2D, 1'b0}, 1'b0);
        wr_byte(8'h10, 1'b0);
        wr_byte(8'h00, 1'b0);
        stop_c;

        // R4 + R8: block code F3h, count 3 from 10h, then two more bytes
        cur_req = "R4";
        set_ptr_read(8'hF3);
        exq.push_back(8'h03);
        for (int a = 8'h10; a <= 8'h12; a++) exq.push_back(mref(a));
        exq.push_back(mref(8'h13));
        exq.push_back(mref(8'h14));
        cur_req = "R8";
        rd_list;
        stop_c;

        cur_req = "R4";
        set_ptr_read(8'hF2);
        exq.push_back(8'h02); exq.push_back(mref(0)); exq.push_back(mref(1));
        rd_list;
        stop_c;

        // R5: unused block codes
        cur_req = "R5";
        set_ptr_read(8'hF9);
        rd_byte(8'h00, 1'b0);
        stop_c;
        set_ptr_read(8'hFD);
        rd_byte(8'h00, 1'b0);
        stop_c;

        // R6: unmapped region
        cur_req = "R6";
        set_ptr_read(8'hBE);
        exq.push_back(mref(8'hBE)); exq.push_back(mref(8'hBF));
        exq.push_back(8'h00); exq.push_back(8'h00);
        rd_list;
        stop_c;
        start_c;
        wr_byte({DEV, 1'b0}, 1'b1);
        wr_byte(8'hC0, 1'b1);
        wr_byte(8'h99, 1'b1);
        stop_c;
        set_ptr_read(8'hC0);
        rd_byte(8'h00, 1'b0);
        stop_c;

        // R7: no wrap past FFh (register 00h is nonzero)
        cur_req = "R7";
        set_ptr_read(8'hFE);
        for (int i = 0; i < 5; i++) exq.push_back(8'h00);
        rd_list;
        stop_c;

        // R9: after NACK the slave stays off the bus
        cur_req = "R9";
        set_ptr_read(8'h20);
        rd_byte(mref(8'h20), 1'b0);
        rd_byte(8'hFF, 1'b0);
        stop_c;

        // R10: STOP in mid-byte writes nothing; START in mid-address restarts matching
        cur_req = "R10";
        start_c;
        wr_byte({DEV, 1'b0}, 1'b1);
        wr_byte(8'h30, 1'b1);
        for (int i = 0; i < 4; i++) bit_w(1'b0, 1'b0);
        stop_c;
        set_ptr_read(8'h30);
        rd_byte(mref(8'h30), 1'b0);
        stop_c;
        start_c;
        bit_w(1'b0, 1'b0); bit_w(1'b1, 1'b0); bit_w(1'b1, 1'b0);
        start_c;
        wr_byte({DEV, 1'b0}, 1'b1);
        wr_byte(8'h30, 1'b1);
        wr_byte(8'h77, 1'b1);
        stop_c;
        ref_mem[8'h30] = 8'h77;
        set_ptr_read(8'h30);
        rd_byte(mref(8'h30), 1'b0);
        stop_c;

        w(20);
        mon_en = 1'b0;
        cur_req = "R11";
        chk(sda_oe == 1'b0, "released when bus idle", {7'd0, sda_oe}, 8'h00);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule